// File: doc/BRIEF.md
# Zero-Idiom Rename Eliminator

This stage sits between instruction decode and register rename and handles a pair of decoded micro-ops each cycle. It looks for register-clearing idioms: an exclusive-or of a register with itself, or a subtraction of a register from itself. The result of either is always zero, whatever the register held before. An op like that does not need a fresh physical register or an execution slot. Its architectural destination is pointed at physical register 0, which always reads as zero. The stage writes the flag outcome at once and sends the op to dispatch marked as already complete.

Every other op, including an immediate load, takes a physical register from the free list through a pop port. The two lanes enter through one valid/ready handshake. Accepted ops are written into the rename table through two write ports and appear on a registered dispatch output one cycle later. Each dispatched op carries a bypass bit that tells the scheduler not to issue it.

Top module: `zi_rename_elim`

## Requirements
- R1: An op with code XOR (1) whose two source indices are equal is an idiom. When it is accepted, its rename write maps the destination to physical register 0 and its dispatch bypass bit is set.
- R2: An op with code SUB (2) whose two source indices are equal is also an idiom and is handled the same way as in R1.
- R3: Codes ALU (0) and LDI (3), and XOR or SUB with different sources, are not idioms. When accepted, such an op maps its destination to a register taken from the free list and has bypass clear.
- R4: In a cycle where at least one accepted op is an idiom, `flag_we` is high and `flag_val` is 4'b0001 (bit0 zero=1, bit1 sign=0, bit2 carry=0, bit3 overflow=0). Otherwise both are zero.
- R5: `fl_pop_cnt` equals the number of accepted non-idiom ops. Idioms never pop, and no pop happens without acceptance.
- R6: Lane 0, if it allocates, takes `fl_preg0`. Lane 1 takes `fl_preg1` when lane 0 also allocates, and `fl_preg0` otherwise.
- R7: When both accepted lanes name the same destination, only lane 1 (the younger) writes the rename table.
- R8: `in_ready` is low when the number of non-idiom valid lanes exceeds `fl_avail` (0, 1, or 2 meaning two or more). While it is low, nothing is written, popped or dispatched.
- R9: Idioms are accepted with an empty free list, whatever is pending on their source register.
- R10: One cycle after an accepted op, `dsp_vld` is high in its lane, with the physical register and bypass bit from R1 to R6. A lane not accepted shows `dsp_vld` low.
- R11: During reset and for two cycles after release, `dsp_vld` and `in_ready` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Decoded pair offered |
| in_ready | output | 1 | Pair accepted this cycle when in_valid is high |
| in_lane_vld | input | 2 | Per-lane op present (bit 0 is the older op) |
| in_op | input | 4 | Per-lane op code, 2 bits each (0 ALU, 1 XOR, 2 SUB, 3 LDI) |
| in_src_a | input | 8 | Per-lane first source index |
| in_src_b | input | 8 | Per-lane second source index |
| in_dst | input | 8 | Per-lane destination index |
| rt_we | output | 2 | Rename table write enables |
| rt_arch | output | 8 | Rename table write indices |
| rt_preg | output | 12 | Rename table physical registers |
| fl_avail | input | 2 | Free registers available (saturating at 2) |
| fl_preg0 | input | 6 | First free physical register |
| fl_preg1 | input | 6 | Second free physical register |
| fl_pop_cnt | output | 2 | Registers consumed this cycle |
| flag_we | output | 1 | Flag write enable |
| flag_val | output | 4 | Flag value {overflow, carry, sign, zero} |
| dsp_vld | output | 2 | Dispatch valid per lane |
| dsp_preg | output | 12 | Dispatch destination physical registers |
| dsp_bypass | output | 2 | Dispatched op is complete and needs no execution |

## Verification
The assertions assume the free list never offers physical register 0 and that `fl_preg0` and `fl_preg1` differ. The random stimulus draws both from 1 and up and forces them apart. Source indices are drawn from a narrow range, so many random ops turn out to be idioms. The free-list count is drawn over 0 to 2, so that stalls, partial allocation and idioms on an empty free list all happen often.

// File: rtl/zi_pkg.sv
package zi_pkg;
  localparam int LANES = 2;

  typedef enum logic [1:0] {
    OP_ALU = 2'd0,
    OP_XOR = 2'd1,
    OP_SUB = 2'd2,
    OP_LDI = 2'd3
  } zi_op_e;

  localparam int FLG_Z = 0;
  localparam int FLG_S = 1;
  localparam int FLG_C = 2;
  localparam int FLG_O = 3;
  localparam int FLG_W = 4;
endpackage

// File: rtl/zi_lane_detect.sv
module zi_lane_detect #(
  parameter int AW = 4
) (
  input  logic [1:0]    op,
  input  logic [AW-1:0] src_a,
  input  logic [AW-1:0] src_b,
  output logic          is_idiom
);
  import zi_pkg::*;

  logic self_pair;
  logic clear_op;

  always_comb begin
    self_pair = (src_a == src_b);
    clear_op  = (op == OP_XOR) || (op == OP_SUB);
    is_idiom  = self_pair && clear_op;
  end
endmodule

// File: rtl/zi_alloc.sv
module zi_alloc #(
  parameter int PW = 6
) (
  input  logic [1:0]    lane_need,
  input  logic [1:0]    fl_avail,
  input  logic [PW-1:0] fl_preg0,
  input  logic [PW-1:0] fl_preg1,
  output logic          can_take,
  output logic [1:0]    need_cnt,
  output logic [PW-1:0] lane0_preg,
  output logic [PW-1:0] lane1_preg
);
  always_comb begin
    need_cnt   = {1'b0, lane_need[0]} + {1'b0, lane_need[1]};
    can_take   = (need_cnt <= fl_avail);
    lane0_preg = fl_preg0;
    lane1_preg = lane_need[0] ? fl_preg1 : fl_preg0;
  end
endmodule

// File: rtl/zi_dispatch_reg.sv
module zi_dispatch_reg #(
  parameter int PW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          acc,
  input  logic [PW-1:0] preg_in,
  input  logic          bypass_in,
  output logic          vld_q,
  output logic [PW-1:0] preg_q,
  output logic          bypass_q
);
  logic          vld_d;
  logic [PW-1:0] preg_d;
  logic          bypass_d;

  always_comb begin
    vld_d    = acc;
    preg_d   = preg_q;
    bypass_d = bypass_q;
    if (acc) begin
      preg_d   = preg_in;
      bypass_d = bypass_in;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q    <= 1'b0;
      preg_q   <= '0;
      bypass_q <= 1'b0;
    end else begin
      vld_q    <= vld_d;
      preg_q   <= preg_d;
      bypass_q <= bypass_d;
    end
  end

  // R10
  dispatch_follows_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc |=> (vld_q && preg_q == $past(preg_in) && bypass_q == $past(bypass_in)));

  // R10
  no_ghost_dispatch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !acc |=> !vld_q);
endmodule

// File: rtl/zi_rename_elim.sv
module zi_rename_elim #(
  parameter int ARCH_REGS = 16,
  parameter int PHYS_REGS = 64
) (
  input  logic                                            clk,
  input  logic                                            rst_n,
  input  logic                                            in_valid,
  output logic                                            in_ready,
  input  logic [zi_pkg::LANES-1:0]                        in_lane_vld,
  input  logic [zi_pkg::LANES*2-1:0]                      in_op,
  input  logic [zi_pkg::LANES*$clog2(ARCH_REGS)-1:0]      in_src_a,
  input  logic [zi_pkg::LANES*$clog2(ARCH_REGS)-1:0]      in_src_b,
  input  logic [zi_pkg::LANES*$clog2(ARCH_REGS)-1:0]      in_dst,
  output logic [zi_pkg::LANES-1:0]                        rt_we,
  output logic [zi_pkg::LANES*$clog2(ARCH_REGS)-1:0]      rt_arch,
  output logic [zi_pkg::LANES*$clog2(PHYS_REGS)-1:0]      rt_preg,
  input  logic [1:0]                                      fl_avail,
  input  logic [$clog2(PHYS_REGS)-1:0]                    fl_preg0,
  input  logic [$clog2(PHYS_REGS)-1:0]                    fl_preg1,
  output logic [1:0]                                      fl_pop_cnt,
  output logic                                            flag_we,
  output logic [zi_pkg::FLG_W-1:0]                        flag_val,
  output logic [zi_pkg::LANES-1:0]                        dsp_vld,
  output logic [zi_pkg::LANES*$clog2(PHYS_REGS)-1:0]      dsp_preg,
  output logic [zi_pkg::LANES-1:0]                        dsp_bypass
);
  import zi_pkg::*;

  localparam int AW = $clog2(ARCH_REGS);
  localparam int PW = $clog2(PHYS_REGS);
  localparam int L  = LANES;
  localparam logic [PW-1:0] ZERO_PREG = '0;

  logic [1:0]    rs_q;
  logic          rst_sync_n;
  logic [L-1:0]  idiom;
  logic [L-1:0]  lane_need;
  logic [L-1:0]  acc;
  logic          alloc_ok;
  logic          fire;
  logic [1:0]    need_cnt;
  logic [PW-1:0] alloc_preg [L];
  logic          same_dst;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_sync_n = rs_q[1];

  for (genvar g = 0; g < L; g++) begin : g_lane
    zi_lane_detect #(.AW(AW)) u_det (
      .op       (in_op[g*2 +: 2]),
      .src_a    (in_src_a[g*AW +: AW]),
      .src_b    (in_src_b[g*AW +: AW]),
      .is_idiom (idiom[g])
    );
    assign lane_need[g] = in_lane_vld[g] & ~idiom[g];
    assign acc[g]       = fire & in_lane_vld[g];
    assign rt_arch[g*AW +: AW] = in_dst[g*AW +: AW];
    assign rt_preg[g*PW +: PW] = idiom[g] ? ZERO_PREG : alloc_preg[g];

    zi_dispatch_reg #(.PW(PW)) u_dsp (
      .clk       (clk),
      .rst_n     (rst_sync_n),
      .acc       (acc[g]),
      .preg_in   (rt_preg[g*PW +: PW]),
      .bypass_in (idiom[g]),
      .vld_q     (dsp_vld[g]),
      .preg_q    (dsp_preg[g*PW +: PW]),
      .bypass_q  (dsp_bypass[g])
    );
  end

  zi_alloc #(.PW(PW)) u_alloc (
    .lane_need  (lane_need),
    .fl_avail   (fl_avail),
    .fl_preg0   (fl_preg0),
    .fl_preg1   (fl_preg1),
    .can_take   (alloc_ok),
    .need_cnt   (need_cnt),
    .lane0_preg (alloc_preg[0]),
    .lane1_preg (alloc_preg[1])
  );

  always_comb begin
    in_ready   = rst_sync_n & alloc_ok;
    fire       = in_valid & in_ready;
    same_dst   = (in_dst[0 +: AW] == in_dst[AW +: AW]);
    rt_we[1]   = acc[1];
    rt_we[0]   = acc[0] & ~(acc[1] & same_dst);
    fl_pop_cnt = fire ? need_cnt : 2'd0;
    flag_we    = |(acc & idiom);
    flag_val   = '0;
    if (flag_we) begin
      flag_val[FLG_Z] = 1'b1;
      flag_val[FLG_S] = 1'b0;
      flag_val[FLG_C] = 1'b0;
      flag_val[FLG_O] = 1'b0;
    end
  end

  // R1
  idiom_maps_zero_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (rt_we[0] && idiom[0]) |-> (rt_preg[0 +: PW] == ZERO_PREG));

  // R3
  alloc_not_zero_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (rt_we[1] && !idiom[1]) |-> (rt_preg[PW +: PW] != ZERO_PREG));

  // R5
  no_overpop_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    fl_pop_cnt <= fl_avail);

  // R7
  younger_wins_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (rt_we[0] && rt_we[1]) |-> (rt_arch[0 +: AW] != rt_arch[AW +: AW]));

  // R8
  stall_quiet_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !in_ready |-> (rt_we == '0 && fl_pop_cnt == 2'd0 && !flag_we));
endmodule

// File: tb/zi_rename_elim_test.sv
module zi_rename_elim_test;
  localparam int AW = 4;
  localparam int PW = 6;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          in_valid;
  logic          in_ready;
  logic [1:0]    in_lane_vld;
  logic [3:0]    in_op;
  logic [7:0]    in_src_a, in_src_b, in_dst;
  logic [1:0]    rt_we;
  logic [7:0]    rt_arch;
  logic [11:0]   rt_preg;
  logic [1:0]    fl_avail;
  logic [PW-1:0] fl_preg0, fl_preg1;
  logic [1:0]    fl_pop_cnt;
  logic          flag_we;
  logic [3:0]    flag_val;
  logic [1:0]    dsp_vld;
  logic [11:0]   dsp_preg;
  logic [1:0]    dsp_bypass;

  int checks = 0;
  int errors = 0;
  logic done = 1'b0;

  logic [1:0]  exp_dvld;
  logic [11:0] exp_dpreg;
  logic [1:0]  exp_dbyp;

  always #2.5 clk = ~clk;

  zi_rename_elim uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_lane_vld(in_lane_vld), .in_op(in_op), .in_src_a(in_src_a),
    .in_src_b(in_src_b), .in_dst(in_dst), .rt_we(rt_we), .rt_arch(rt_arch),
    .rt_preg(rt_preg), .fl_avail(fl_avail), .fl_preg0(fl_preg0),
    .fl_preg1(fl_preg1), .fl_pop_cnt(fl_pop_cnt), .flag_we(flag_we),
    .flag_val(flag_val), .dsp_vld(dsp_vld), .dsp_preg(dsp_preg),
    .dsp_bypass(dsp_bypass)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic is_idiom(input logic [1:0] op, input logic [3:0] a, input logic [3:0] b);
    return (op == 2'd1 || op == 2'd2) && (a == b);
  endfunction

  task automatic drive(input logic v, input logic [1:0] lv, input logic [3:0] op,
                       input logic [7:0] sa, input logic [7:0] sb, input logic [7:0] d,
                       input logic [1:0] av, input logic [5:0] p0, input logic [5:0] p1);
    in_valid = v; in_lane_vld = lv; in_op = op; in_src_a = sa; in_src_b = sb;
    in_dst = d; fl_avail = av; fl_preg0 = p0; fl_preg1 = p1;
  endtask

  // Applies at the falling edge, checks combinational outputs, then registered dispatch.
  task automatic step(input string tag, input logic v, input logic [1:0] lv, input logic [3:0] op,
                      input logic [7:0] sa, input logic [7:0] sb, input logic [7:0] d,
                      input logic [1:0] av, input logic [5:0] p0, input logic [5:0] p1);
    logic [1:0] id, need, acc, we;
    logic [5:0] pr [2];
    logic       rdy, fire;
    int         ncnt;
    @(negedge clk);
    drive(v, lv, op, sa, sb, d, av, p0, p1);
    #1;
    for (int i = 0; i < 2; i++) begin
      id[i]   = is_idiom(op[i*2 +: 2], sa[i*4 +: 4], sb[i*4 +: 4]);
      need[i] = lv[i] && !id[i];
    end
    ncnt = int'(need[0]) + int'(need[1]);
    rdy  = (ncnt <= int'(av));
    fire = v && rdy;
    for (int i = 0; i < 2; i++) acc[i] = fire && lv[i];
    we[1] = acc[1];
    we[0] = acc[0] && !(acc[1] && d[3:0] == d[7:4]);
    pr[0] = id[0] ? 6'd0 : p0;
    pr[1] = id[1] ? 6'd0 : (need[0] ? p1 : p0);
    chk({tag, " R8 ready"}, in_ready, rdy);
    chk({tag, " R7 rt_we"}, rt_we, we);
    chk({tag, " R5 pop"}, fl_pop_cnt, fire ? ncnt : 0);
    chk({tag, " R4 flag_we"}, flag_we, |(acc & id));
    chk({tag, " R4 flag_val"}, flag_val, (|(acc & id)) ? 4'b0001 : 4'b0000);
    for (int i = 0; i < 2; i++) if (we[i]) begin
      chk({tag, " R6 rt_preg"}, rt_preg[i*PW +: PW], pr[i]);
      chk({tag, " R7 rt_arch"}, rt_arch[i*AW +: AW], d[i*4 +: 4]);
    end
    exp_dvld = acc;
    exp_dpreg = {pr[1], pr[0]};
    exp_dbyp = id;
    @(posedge clk);
    #1;
    chk({tag, " R10 dsp_vld"}, dsp_vld, exp_dvld);
    for (int i = 0; i < 2; i++) if (exp_dvld[i]) begin
      chk({tag, " R10 dsp_preg"}, dsp_preg[i*PW +: PW], exp_dpreg[i*PW +: PW]);
      chk({tag, " R10 dsp_bypass"}, dsp_bypass[i], exp_dbyp[i]);
    end
  endtask

  initial begin
    #200000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] seed_v;
    seed_v = $urandom(32'd20240611);
    rst_n = 1'b0;
    drive(1'b0, 2'b00, 4'h0, 8'h00, 8'h00, 8'h00, 2'd2, 6'd5, 6'd6);
    repeat (3) @(posedge clk);
    #1;
    // R11 reset state
    chk("R11 dsp_vld in reset", dsp_vld, 2'b00);
    chk("R11 ready in reset", in_ready, 1'b0);
    @(negedge clk); rst_n = 1'b1;
    #1;
    chk("R11 ready after release", in_ready, 1'b0);
    repeat (2) @(posedge clk);

    // R1 XOR self on lane0, ALU on lane1
    step("R1", 1'b1, 2'b11, {2'd0, 2'd1}, 8'h23, 8'h53, 8'h74, 2'd2, 6'd9, 6'd10);
    // R2 SUB self on lane1
    step("R2", 1'b1, 2'b11, {2'd2, 2'd0}, 8'h61, 8'h62, 8'h34, 2'd2, 6'd11, 6'd12);
    // R3 LDI and XOR with differing sources allocate
    step("R3", 1'b1, 2'b11, {2'd1, 2'd3}, 8'h45, 8'h55, 8'h89, 2'd2, 6'd13, 6'd14);
    chk("R3 lane0 bypass", dsp_bypass[0], 1'b0);
    // R9 two idioms with empty free list
    step("R9", 1'b1, 2'b11, {2'd2, 2'd1}, 8'h77, 8'h77, 8'h21, 2'd0, 6'd15, 6'd16);
    chk("R9 accepted", dsp_vld, 2'b11);
    // R8 stall: one allocation needed, none free
    step("R8", 1'b1, 2'b01, {2'd0, 2'd0}, 8'h12, 8'h34, 8'h05, 2'd0, 6'd17, 6'd18);
    // R7 same destination, younger wins
    step("R7", 1'b1, 2'b11, {2'd0, 2'd1}, 8'h33, 8'h43, 8'h99, 2'd2, 6'd19, 6'd20);
    // R6 only lane1 allocates, takes fl_preg0
    step("R6", 1'b1, 2'b11, {2'd0, 2'd2}, 8'h28, 8'h38, 8'hA1, 2'd1, 6'd21, 6'd22);

    for (int n = 0; n < 600; n++) begin
      logic [5:0] p0, p1;
      p0 = 6'($urandom_range(1, 63));
      p1 = 6'($urandom_range(1, 62));
      if (p1 >= p0) p1 = p1 + 6'd1;
      if (p1 == 6'd0) p1 = 6'd1;
      step("rand", ($urandom_range(0, 7) != 0), 2'($urandom_range(0, 3)),
           4'($urandom), {4'($urandom_range(0, 3)), 4'($urandom_range(0, 3))},
           {4'($urandom_range(0, 3)), 4'($urandom_range(0, 3))},
           {4'($urandom_range(0, 3)), 4'($urandom_range(0, 3))},
           2'($urandom_range(0, 2)), p0, p1);
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule